// File: doc/BRIEF.md
# Replicated Scanline Line Buffer

This block sits between a byte producer (a CPU copy loop or a DMA engine) and a video pixel pipeline that drains at a steady pixel rate. It is used when each stored row is shown on several consecutive scanlines: 2 for 320-wide modes, 4 for 160-wide modes. The block holds a bank of identical first-in first-out buffers, one for each repeated scanline. Every byte the producer writes goes into all buffers in the same cycle, so one row of data is supplied once and can then be replayed once per repeat.

On the video side, the scanline's position within its repeat group, `line_sel`, picks the buffer that supplies pixels. Pixels are 4 bits wide and two are packed in each byte, so a 320-pixel row is 160 bytes. The block unpacks each byte into two pixels and emits the high nibble first. A refill request rises when the selected buffer is half empty, so the producer can burst-load the next bytes. Misuse is recorded in two sticky flags, one for overflow and one for underrun.

Producer and display share one clock and are paced by their own strobes. `rst_n` is asserted asynchronously and is released in step with `clk`.

Top module: `scanrep_linebuf`

## Requirements
- R1: When `wr_en` is high, `wr_data` is appended to every buffer that is not full. All buffers therefore receive the same byte sequence.
- R2: Pixels are taken only from buffer number `line_sel` (0 for the first scanline of a group, 1 for the second, and so on). The other buffers are left untouched.
- R3: Each buffer holds DEPTH = 160 bytes. After a reset, 160 consecutive writes are all accepted and none of them sets `overflow`.
- R4: `pix_out` is registered. A pixel requested by `pix_en` at one clock edge is valid from that edge until the next pixel is taken.
- R5: The first `pix_en` of a byte pops the selected buffer and outputs bits [7:4] of the byte.
- R6: The second `pix_en` of a byte outputs bits [3:0] of the held byte and pops nothing.
- R7: `refill_req` is set one cycle after the selected buffer holds at most DEPTH/2 bytes. It is cleared one cycle after that buffer holds exactly DEPTH bytes, and it holds its value in between.
- R8: A write while any buffer is full is dropped by every full buffer and sets `overflow`, which stays high until reset.
- R9: A byte pop from an empty buffer gives a pixel value of 0 for both nibbles and sets `underrun`, which stays high until reset.
- R10: While `rst_n` is low, all buffers are empty and `pix_out`, `refill_req`, `overflow` and `underrun` are 0. The high/low nibble phase restarts at the high nibble.
- R11: In a cycle without `pix_en`, `pix_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Producer write strobe, broadcast to all buffers |
| wr_data | input | 8 | Producer byte, two packed 4-bit pixels |
| line_sel | input | $clog2(NUM_BUF) | Scanline index within the repeat group |
| pix_en | input | 1 | Pixel strobe from the video side |
| pix_out | output | 4 | Current pixel value |
| refill_req | output | 1 | Burst refill request with hysteresis |
| overflow | output | 1 | Sticky: write attempted while a buffer was full |
| underrun | output | 1 | Sticky: pixel byte requested from an empty buffer |

## Verification
Some properties are checked on every cycle: the two status flags stay set once raised, `pix_out` is stable in cycles without a pixel strobe, and `refill_req` only rises after the selected fill level was at or below half and only falls after it reached full. Other behaviour can only be shown by the bench's scenarios against its reference model. These are the replay of an identical byte sequence from each buffer, the nibble order, the selection by scanline index, the exact capacity of 160 bytes, and the zero pixels returned on underrun.

// File: rtl/scanrep_pkg.sv
package scanrep_pkg;
  localparam int BYTE_W = 8;
  localparam int PIX_W  = BYTE_W / 2;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PIX_W-1:0]  pix_t;
endpackage

// File: rtl/scanrep_fifo.sv
module scanrep_fifo
  import scanrep_pkg::*;
#(
  parameter int DEPTH = 160,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  byte_t            din,
  output byte_t            head,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  byte_t            store [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] lvl_q, lvl_d;
  logic             do_push, do_pop;

  assign full    = (lvl_q == CNT_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rp_q];
  assign level   = lvl_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      lvl_d = lvl_q + 1'b1;
    else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wp_q] <= din;
  end
endmodule

// File: rtl/scanrep_unpack.sv
module scanrep_unpack
  import scanrep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pix_en,
  input  byte_t head,
  input  logic  empty,
  output logic  pop,
  output logic  starve,
  output pix_t  pix_out
);
  logic  lo_q, lo_d;
  byte_t hold_q, hold_d;
  pix_t  pix_q, pix_d;

  assign pop    = pix_en && !lo_q;
  assign starve = pop && empty;

  always_comb begin
    lo_d   = lo_q;
    hold_d = hold_q;
    pix_d  = pix_q;
    if (pix_en) begin
      lo_d = !lo_q;
      if (!lo_q) begin
        hold_d = empty ? '0 : head;
        pix_d  = hold_d[BYTE_W-1:PIX_W];
      end else begin
        pix_d = hold_q[PIX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= 1'b0;
      hold_q <= '0;
      pix_q  <= '0;
    end else begin
      lo_q   <= lo_d;
      hold_q <= hold_d;
      pix_q  <= pix_d;
    end
  end

  assign pix_out = pix_q;
endmodule

// File: rtl/scanrep_refill.sv
module scanrep_refill #(
  parameter int DEPTH = 160,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  output logic             req
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(DEPTH);

  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (level <= HALF)     req_d = 1'b1;
    else if (level == TOP) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/scanrep_linebuf.sv
module scanrep_linebuf
  import scanrep_pkg::*;
#(
  parameter int NUM_BUF = 2,
  parameter int DEPTH   = 160,
  parameter int SEL_W   = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [SEL_W-1:0] line_sel,
  input  logic             pix_en,
  output logic [3:0]       pix_out,
  output logic             refill_req,
  output logic             overflow,
  output logic             underrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  byte_t            head_a [NUM_BUF];
  logic [CNT_W-1:0] lvl_a  [NUM_BUF];
  logic [NUM_BUF-1:0] full_v, empty_v;
  logic             pop_req, starve;
  logic [CNT_W-1:0] cnt_sel;
  logic             ovf_q, ovf_d, udr_q, udr_d;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    scanrep_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_en),
      .pop   (pop_req && (line_sel == SEL_W'(b))),
      .din   (wr_data),
      .head  (head_a[b]),
      .level (lvl_a[b]),
      .full  (full_v[b]),
      .empty (empty_v[b])
    );
  end

  assign cnt_sel = lvl_a[line_sel];

  scanrep_unpack unpack_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_en  (pix_en),
    .head    (head_a[line_sel]),
    .empty   (empty_v[line_sel]),
    .pop     (pop_req),
    .starve  (starve),
    .pix_out (pix_out)
  );

  scanrep_refill #(.DEPTH(DEPTH), .CNT_W(CNT_W)) refill_i (
    .clk   (clk),
    .rst_n (rst_n),
    .level (cnt_sel),
    .req   (refill_req)
  );

  always_comb begin
    ovf_d = ovf_q || (wr_en && (|full_v));
    udr_d = udr_q || starve;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udr_q <= udr_d;
    end
  end

  assign overflow = ovf_q;
  assign underrun = udr_q;
endmodule

// File: rtl/scanrep_linebuf_chk.sv
module scanrep_linebuf_chk #(
  parameter int DEPTH = 160,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic [3:0]       pix_out,
  input logic             refill_req,
  input logic             overflow,
  input logic             underrun,
  input logic [CNT_W-1:0] cnt_sel
);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R11
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(pix_out));

  // R7
  refill_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refill_req) |-> ($past(cnt_sel) <= CNT_W'(DEPTH / 2)));

  // R7
  refill_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refill_req) |-> ($past(cnt_sel) == CNT_W'(DEPTH)));
endmodule

bind scanrep_linebuf scanrep_linebuf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_en     (pix_en),
  .pix_out    (pix_out),
  .refill_req (refill_req),
  .overflow   (overflow),
  .underrun   (underrun),
  .cnt_sel    (cnt_sel)
);

// File: tb/scanrep_linebuf_tb.sv
module scanrep_linebuf_tb_top;
  localparam int NB    = 4;
  localparam int DEPTH = 160;
  localparam int SW    = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic [SW-1:0] line_sel;
  logic          pix_en;
  logic [3:0]    pix_out;
  logic          refill_req, overflow, underrun;

  always #10 clk = !clk;

  scanrep_linebuf #(.NUM_BUF(NB), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .line_sel(line_sel), .pix_en(pix_en), .pix_out(pix_out),
    .refill_req(refill_req), .overflow(overflow), .underrun(underrun)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state
  int mem [NB][DEPTH];
  int mh [NB];
  int mc [NB];
  int m_ph, m_byte, m_pix, m_req, m_ovf, m_udr;
  string pix_tag = "R5";

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int b = 0; b < NB; b++) begin mh[b] = 0; mc[b] = 0; end
    m_ph = 0; m_byte = 0; m_pix = 0; m_req = 0; m_ovf = 0; m_udr = 0;
  endfunction

  function automatic void model_clock(input bit w, input int d, input bit p, input int s);
    bit full_b [NB];
    bit anyfull = 0;
    int cs = mc[s];
    for (int b = 0; b < NB; b++) begin
      full_b[b] = (mc[b] == DEPTH);
      anyfull |= full_b[b];
    end
    if (p) begin
      if (m_ph == 0) begin
        if (mc[s] == 0) begin m_byte = 0; m_udr = 1; end
        else begin
          m_byte = mem[s][mh[s]];
          mh[s] = (mh[s] + 1) % DEPTH;
          mc[s]--;
        end
        m_pix = m_byte >> 4;
      end else m_pix = m_byte & 15;
      m_ph ^= 1;
    end
    if (w) for (int b = 0; b < NB; b++)
      if (!full_b[b]) begin
        mem[b][(mh[b] + mc[b]) % DEPTH] = d;
        mc[b]++;
      end
    if (w && anyfull) m_ovf = 1;
    if (cs <= DEPTH / 2) m_req = 1;
    else if (cs == DEPTH) m_req = 0;
  endfunction

  task automatic step(input bit w, input int d, input bit p, input int s);
    wr_en = w; wr_data = d[7:0]; pix_en = p; line_sel = s[SW-1:0];
    @(posedge clk);
    model_clock(w, d, p, s);
    @(negedge clk);
    check(pix_tag, pix_out, m_pix);
    check("R7", refill_req, m_req);
    check("R8", overflow, m_ovf);
    check("R9", underrun, m_udr);
  endtask

  task automatic do_reset();
    wr_en = 0; pix_en = 0; wr_data = 0; line_sel = 0;
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    model_reset();
    check("R10", pix_out, 0);
    check("R10", refill_req, 0);
    check("R10", overflow, 0);
    check("R10", underrun, 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int first_pix;
    void'($urandom(32'd2024));
    do_reset();
    step(0, 0, 0, 0);
    check("R7", refill_req, 1);

    // nibble order and broadcast
    step(1, 8'hA5, 0, 0);
    step(0, 0, 1, 0);
    check("R5", pix_out, 4'hA);
    step(0, 0, 1, 0);
    check("R6", pix_out, 4'h5);
    step(0, 0, 0, 0);
    check("R11", pix_out, 4'h5);
    pix_tag = "R2";
    step(0, 0, 1, 1);
    check("R1", pix_out, 4'hA);
    step(0, 0, 1, 1);

    // capacity, refill hysteresis, overflow
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, $urandom % 256, 0, 0);
    check("R3", overflow, 0);
    step(0, 0, 0, 0);
    check("R7", refill_req, 0);
    step(1, 8'h3C, 0, 2);
    check("R8", overflow, 1);

    // replay the same row from each buffer in turn
    pix_tag = "R1";
    for (int s = 0; s < NB; s++) begin
      for (int k = 0; k < 2 * DEPTH; k++) begin
        step(0, 0, 1, s);
        if (k == 0 && s == 0) first_pix = pix_out;
        if (k == 0 && s != 0) check("R2", pix_out, first_pix);
      end
    end

    // underrun on an empty buffer
    pix_tag = "R9";
    step(0, 0, 1, 3);
    check("R9", pix_out, 0);
    check("R9", underrun, 1);
    step(0, 0, 1, 3);
    check("R9", pix_out, 0);
    do_reset();
    check("R10", underrun, 0);

    // random mixed traffic
    pix_tag = "R4";
    begin
      int s = 0;
      for (int i = 0; i < 6000; i++) begin
        if (m_ph == 0 && ($urandom % 40) == 0) s = $urandom % NB;
        step(($urandom % 3) == 0, $urandom % 256, ($urandom % 2) == 0, s);
      end
    end
    do_reset();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule